// File: doc/BRIEF.md
# Two-Bit State Machine with Shared-Divisor Next-State Logic

This block is a two-bit synchronous state machine driven by two data inputs. Its next-state functions are fixed sum-of-products equations. The register is loaded from a multi-level version of those equations. In that version a single divisor term, the OR of the two inverted signals q0 and a, is built once and feeds both next-state bits.

Beside the factored logic, the block computes the same next-state pair in flat two-level form and drives both results out as combinational outputs. An environment can therefore show that the restructured logic matches the original equations for every input and state combination. The state bits themselves are outputs.

The reset input asserts asynchronously. Its release passes through a two-stage synchronizer before it reaches the state register, so the first state update happens on the third rising edge after the reset input goes high.

Top module: `fsm2_factored`

## Requirements
- R1: While `rst_n` is low, the state {q1,q0} is 00, and a falling `rst_n` clears the state at once, with no clock edge needed.
- R2: After `rst_n` rises, the state holds 00 on the first two rising clock edges whatever the inputs are, and it begins following the next-state logic on the third rising edge.
- R3: `nxt_flat[0]` equals b·q1'·q0' + a'·b·q1' + a'·b·q0', so it is 0 whenever b is 0.
- R4: `nxt_flat[1]` equals q1·q0' + a'·q1 + b·q0, so it is 1 whenever q1=1 and q0=0.
- R5: `nxt_fact` is built from one shared divisor c = q0' + a'. Bit 1 is c·q1 + b·q0 and bit 0 is b·(c·q1' + a'·q0'). `nxt_fact` equals `nxt_flat` for all 16 combinations of {a,b,q1,q0}.
- R6: Out of reset, each rising clock edge loads {q1,q0} with the value `nxt_fact` held just before that edge.
- R7: The next-state outputs are combinational. They change in the same cycle as a change on `a`, `b` or the state, and bit 1 of each vector is the next q1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases through a synchronizer |
| a | input | 1 | Data input a |
| b | input | 1 | Data input b |
| q1 | output | 1 | State bit q1 |
| q0 | output | 1 | State bit q0 |
| nxt_fact | output | 2 | Next state from the factored logic, {q1,q0} order |
| nxt_flat | output | 2 | Next state from the flat two-level equations, {q1,q0} order |

## Verification
Four properties are checked on every clock cycle out of reset. The factored and flat next-state vectors must agree. The register must load the factored value. The next q0 must be low whenever b is low. The next q1 must be high in state 10. A fifth property holds the state at 00 while the reset input is low. Several behaviours can only be shown by the bench's scenarios: the exact edge on which a synchronised reset release first lets the state move, the clearing of the state in the middle of a cycle, and the value of each equation in each of the 16 input and state combinations, which the bench reaches by steering the machine through its transitions.

// File: rtl/fsm2_pkg.sv
`timescale 1ns/1ps
package fsm2_pkg;
  localparam int ST_W  = 2;
  localparam int IN_W  = 2;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic q1;
    logic q0;
  } st_t;

  typedef struct packed {
    logic a;
    logic b;
  } din_t;

  localparam st_t ST_IDLE = '{q1: 1'b0, q0: 1'b0};
endpackage

// File: rtl/fsm2_rst_sync.sv
`timescale 1ns/1ps
module fsm2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fsm2_next_flat.sv
`timescale 1ns/1ps
module fsm2_next_flat
  import fsm2_pkg::*;
(
  input  st_t  cur,
  input  din_t din,
  output st_t  nxt
);
  // Two-level sum-of-products form, one product term per line.
  always_comb begin
    nxt.q0 = ( din.b &  ~cur.q1 & ~cur.q0)
           | (~din.a &   din.b  & ~cur.q1)
           | (~din.a &   din.b  & ~cur.q0);
    nxt.q1 = ( cur.q1 & ~cur.q0)
           | (~din.a &  cur.q1)
           | ( din.b &  cur.q0);
  end
endmodule

// File: rtl/fsm2_next_fact.sv
`timescale 1ns/1ps
module fsm2_next_fact
  import fsm2_pkg::*;
(
  input  st_t  cur,
  input  din_t din,
  output st_t  nxt
);
  logic div_c;   // shared divisor, built once

  always_comb begin
    div_c  = ~cur.q0 | ~din.a;
    nxt.q1 = (div_c & cur.q1) | (din.b & cur.q0);
    nxt.q0 = din.b & ((div_c & ~cur.q1) | (~din.a & ~cur.q0));
  end
endmodule

// File: rtl/fsm2_factored.sv
`timescale 1ns/1ps
module fsm2_factored
  import fsm2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  output logic       q1,
  output logic       q0,
  output logic [1:0] nxt_fact,
  output logic [1:0] nxt_flat
);
  logic rst_sync_n;
  st_t  st_q;
  st_t  st_d;
  st_t  fact_w;
  st_t  flat_w;
  din_t din_w;

  assign din_w = '{a: a, b: b};

  fsm2_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_sync_n)
  );

  fsm2_next_fact fact_i (.cur(st_q), .din(din_w), .nxt(fact_w));
  fsm2_next_flat flat_i (.cur(st_q), .din(din_w), .nxt(flat_w));

  // next-state process
  always_comb begin
    st_d = fact_w;
  end

  // register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  assign q1       = st_q.q1;
  assign q0       = st_q.q0;
  assign nxt_fact = {fact_w.q1, fact_w.q0};
  assign nxt_flat = {flat_w.q1, flat_w.q0};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> ({q1, q0} == 2'b00));

  // R5
  form_equal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nxt_fact == nxt_flat);

  // R6
  state_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ({q1, q0} == $past(nxt_fact)));

  // R3
  d0_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !b |-> !nxt_flat[0]);

  // R4
  hold_q1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q1 && !q0) |-> nxt_flat[1]);
endmodule

// File: tb/fsm2_factored_tb_top.sv
`timescale 1ns/1ps
module fsm2_factored_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a = 1'b0;
  logic       b = 1'b0;
  logic       q1, q0;
  logic [1:0] nxt_fact, nxt_flat;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fsm2_factored dut_i (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b),
    .q1(q1), .q0(q0), .nxt_fact(nxt_fact), .nxt_flat(nxt_flat)
  );

  function automatic logic [1:0] ref_next(logic ia, logic ib, logic [1:0] s);
    logic s1, s0, n1, n0;
    s1 = s[1]; s0 = s[0];
    n0 = (ib & !s1 & !s0) | (!ia & ib & !s1) | (!ia & ib & !s0);
    n1 = (s1 & !s0) | (!ia & s1) | (ib & s0);
    return {n1, n0};
  endfunction

  task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic step(logic ia, logic ib);
    @(negedge clk);
    a = ia; b = ib;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; a = 1'b0; b = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic goto_state(logic [1:0] tgt);
    do_reset();
    case (tgt)
      2'b01: step(1'b0, 1'b1);
      2'b11: begin step(1'b0, 1'b1); step(1'b0, 1'b1); end
      2'b10: begin step(1'b0, 1'b1); step(1'b1, 1'b1); end
      default: ;
    endcase
    check("R6 steer", {q1, q0}, tgt);
  endtask

  initial begin
    logic [1:0] model;
    // R1: state cleared while reset held
    repeat (3) @(posedge clk);
    #1 check("R1 held reset", {q1, q0}, 2'b00);

    // R2: synchronised release with b high
    @(negedge clk);
    b = 1'b1; a = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1 check("R2 edge1", {q1, q0}, 2'b00);
    @(posedge clk); #1 check("R2 edge2", {q1, q0}, 2'b00);
    @(posedge clk); #1 check("R2 edge3", {q1, q0}, 2'b01);

    // R1: mid-cycle asynchronous clear from a non-zero state
    @(negedge clk); #3 rst_n = 1'b0;
    #1 check("R1 async clear", {q1, q0}, 2'b00);

    // R3 R4 R5 R6 R7: all 16 combinations
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 4; i++) begin
        logic [1:0] exp;
        goto_state(s[1:0]);
        @(negedge clk);
        a = i[1]; b = i[0];
        #1;
        exp = ref_next(i[1], i[0], s[1:0]);
        check("R3 flat q0", {1'b0, nxt_flat[0]}, {1'b0, exp[0]});
        check("R4 flat q1", {1'b0, nxt_flat[1]}, {1'b0, exp[1]});
        check("R5 factored", nxt_fact, exp);
        check("R7 comb order", nxt_fact, exp);
        @(posedge clk); #1;
        check("R6 load", {q1, q0}, exp);
      end
    end

    // R5 R6: random sequence tracked by a model
    do_reset();
    model = 2'b00;
    for (int n = 0; n < 400; n++) begin
      logic ia, ib;
      ia = 1'($urandom); ib = 1'($urandom);
      @(negedge clk);
      a = ia; b = ib;
      #1 check("R5 random", nxt_fact, ref_next(ia, ib, model));
      @(posedge clk); #1;
      model = ref_next(ia, ib, model);
      check("R6 random", {q1, q0}, model);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule